// File: doc/BRIEF.md
# Video Timing Status and Compare Registers

This block is the CPU-facing register slice of a console-style video timing unit. It watches the live horizontal and vertical dot counters, the active display height, a controller auto-poll busy indication and two interrupt event pulses. From these it builds byte-wide status registers for the CPU to read. Bits that carry no status are filled from the open-bus byte that the system bus offers on the same read.

The block also holds the two programmable interrupt compare positions, horizontal and vertical. Each is 9 bits wide and the CPU writes it as a low byte plus a single-bit high byte. The horizontal position is held in a pre-scaled form, four times the position plus one, so that the compare logic can match it directly against a dot counter that runs four times faster. Every write to it decodes the stored form, replaces the written bits and encodes the result again.

The two interrupt flags latch their event pulses. A CPU read of a flag's register acknowledges that flag. Read data is registered: a read requested in one cycle appears on `rd_data` in the next cycle and stays there until the next read.

Top module: `vt_status_regs`

## Requirements
- R1: When register select 0 (timing status) is read, `rd_data` bit 0 equals `poll_busy` and bits 5..1 equal `bus_in` bits 5..1. All values are those sampled in the read cycle.
- R2: Timing status bit 6 is 1 exactly when `hpos` is 2 or less, or 1096 or more.
- R3: Timing status bit 7 is 1 exactly when `vpos` is greater than or equal to `disp_height`.
- R4: When register select 1 (NMI status) is read, bit 7 is the NMI flag, bits 6..4 are `bus_in` bits 6..4, and bits 3..0 are the `VERSION` parameter (default 2).
- R5: When register select 2 (timer status) is read, bit 7 is the timer flag and bits 6..0 are `bus_in` bits 6..0.
- R6: A `nmi_set` or `timer_set` pulse sets its flag in the next cycle. Reading the flag's register clears the flag in the next cycle. If a set pulse arrives in the same cycle as the read, the flag stays set and the read returns the flag's earlier value. The flag is visible on `nmi_flag` and `timer_flag`.
- R7: The horizontal compare position n is output as `hcmp_enc` = (n+1)*4 (12 bits). A write to select 3 replaces n[7:0] with `wr_data`. A write to select 4 replaces n[8] with `wr_data` bit 0 and ignores the other data bits.
- R8: The vertical compare position is output unscaled on `vcmp`. Select 5 writes bits 7..0 and select 6 writes bit 8 from `wr_data` bit 0.
- R9: After reset `rd_data` is 0, both flags are 0, `vcmp` is 0x1FF and `hcmp_enc` is 0x800 (position 0x1FF).
- R10: A read of any select other than 0, 1 or 2 returns `bus_in` unchanged. Without a read, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | CPU read strobe, one cycle |
| wr_en | input | 1 | CPU write strobe, one cycle |
| sel | input | 3 | Register select |
| wr_data | input | 8 | CPU write data |
| bus_in | input | 8 | Open-bus byte for unused read bits |
| hpos | input | 11 | Horizontal dot counter |
| vpos | input | 9 | Vertical line counter |
| disp_height | input | 9 | Active display height in lines |
| poll_busy | input | 1 | Auto-poll in progress |
| nmi_set | input | 1 | NMI event pulse |
| timer_set | input | 1 | Timer event pulse |
| rd_data | output | 8 | Registered read data |
| nmi_flag | output | 1 | Latched NMI flag |
| timer_flag | output | 1 | Latched timer flag |
| hcmp_enc | output | 12 | Horizontal compare, encoded (n+1)*4 |
| vcmp | output | 9 | Vertical compare position |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that every input is a defined value while reset is low. The bench drives one strobe at a time, always on the falling clock edge, and holds every input at a known value from time zero. Its flag scenario places a set pulse on top of a read on purpose, because that overlap is the corner that R6 defines.

// File: rtl/vt_regs_pkg.sv
package vt_regs_pkg;
  typedef enum logic [2:0] {
    SEL_HVSTAT  = 3'd0,
    SEL_NMISTAT = 3'd1,
    SEL_TMSTAT  = 3'd2,
    SEL_HCMP_LO = 3'd3,
    SEL_HCMP_HI = 3'd4,
    SEL_VCMP_LO = 3'd5,
    SEL_VCMP_HI = 3'd6,
    SEL_NONE    = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/vt_event_flag.sv
module vt_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (ack_i) flag_o <= 1'b0;
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o); // R6
  AST_FLAG_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !set_i) |=> !flag_o); // R6
endmodule

// File: rtl/vt_hv_decode.sv
module vt_hv_decode #(
  parameter int HPOS_W  = 11,
  parameter int VPOS_W  = 9,
  parameter int HBL_END = 2,
  parameter int HBL_BEG = 1096
) (
  input  logic [HPOS_W-1:0] hpos,
  input  logic [VPOS_W-1:0] vpos,
  input  logic [VPOS_W-1:0] disp_height,
  input  logic              poll_busy,
  input  logic [7:0]        bus_in,
  output logic [7:0]        status
);
  localparam logic [HPOS_W-1:0] H_END = HPOS_W'(HBL_END);
  localparam logic [HPOS_W-1:0] H_BEG = HPOS_W'(HBL_BEG);

  logic in_hblank, in_vblank;
  always_comb begin
    in_hblank = (hpos <= H_END) || (hpos >= H_BEG);
    in_vblank = (vpos >= disp_height);
    status    = {in_vblank, in_hblank, bus_in[5:1], poll_busy};
  end
endmodule

// File: rtl/vt_cmp_reg.sv
module vt_cmp_reg #(
  parameter int VAL_W  = 9,
  parameter bit SCALED = 1'b0,
  parameter int OUT_W  = SCALED ? VAL_W + 3 : VAL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       data,
  output logic [OUT_W-1:0] value
);
  localparam logic [VAL_W-1:0] RST_POS = '1;

  logic [VAL_W-1:0] pos_cur, pos_nxt;

  always_comb begin
    pos_nxt = pos_cur;
    if (wr_lo) pos_nxt[7:0] = data;
    if (wr_hi) pos_nxt[VAL_W-1:8] = data[VAL_W-9:0];
  end

  generate
    if (SCALED) begin : g_scaled
      localparam int ENC_W = VAL_W + 1;
      logic [ENC_W-1:0] enc_q;
      logic [ENC_W-1:0] dec_tmp;
      always_comb begin
        dec_tmp = enc_q - ENC_W'(1);
        pos_cur = dec_tmp[VAL_W-1:0];
      end
      always_ff @(posedge clk) begin
        if (rst)                enc_q <= {1'b0, RST_POS} + ENC_W'(1);
        else if (wr_lo || wr_hi) enc_q <= {1'b0, pos_nxt} + ENC_W'(1);
      end
      assign value = {enc_q, 2'b00};
    end else begin : g_raw
      logic [VAL_W-1:0] raw_q;
      assign pos_cur = raw_q;
      always_ff @(posedge clk) begin
        if (rst)                raw_q <= RST_POS;
        else if (wr_lo || wr_hi) raw_q <= pos_nxt;
      end
      assign value = raw_q;
    end
  endgenerate

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo && !wr_hi) |=> $stable(value)); // R7
  AST_CMP_LO_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (pos_cur[7:0] == $past(data))); // R8
endmodule

// File: rtl/vt_status_regs.sv
module vt_status_regs #(
  parameter int HPOS_W  = 11,
  parameter int VPOS_W  = 9,
  parameter int CMP_W   = 9,
  parameter int HBL_END = 2,
  parameter int HBL_BEG = 1096,
  parameter logic [3:0] VERSION = 4'd2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [2:0]          sel,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          bus_in,
  input  logic [HPOS_W-1:0]   hpos,
  input  logic [VPOS_W-1:0]   vpos,
  input  logic [VPOS_W-1:0]   disp_height,
  input  logic                poll_busy,
  input  logic                nmi_set,
  input  logic                timer_set,
  output logic [7:0]          rd_data,
  output logic                nmi_flag,
  output logic                timer_flag,
  output logic [CMP_W+2:0]    hcmp_enc,
  output logic [CMP_W-1:0]    vcmp
);
  import vt_regs_pkg::*;

  reg_sel_e   sel_e;
  logic [7:0] hv_byte, rd_mux;
  logic       ack_nmi, ack_tm;

  assign sel_e   = reg_sel_e'(sel);
  assign ack_nmi = rd_en && (sel_e == SEL_NMISTAT);
  assign ack_tm  = rd_en && (sel_e == SEL_TMSTAT);

  vt_hv_decode #(
    .HPOS_W(HPOS_W), .VPOS_W(VPOS_W), .HBL_END(HBL_END), .HBL_BEG(HBL_BEG)
  ) u_hv (
    .hpos(hpos), .vpos(vpos), .disp_height(disp_height),
    .poll_busy(poll_busy), .bus_in(bus_in), .status(hv_byte)
  );

  vt_event_flag u_nmi (
    .clk(clk), .rst(rst), .set_i(nmi_set), .ack_i(ack_nmi), .flag_o(nmi_flag)
  );
  vt_event_flag u_tm (
    .clk(clk), .rst(rst), .set_i(timer_set), .ack_i(ack_tm), .flag_o(timer_flag)
  );

  vt_cmp_reg #(.VAL_W(CMP_W), .SCALED(1'b1)) u_hcmp (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (sel_e == SEL_HCMP_LO)),
    .wr_hi(wr_en && (sel_e == SEL_HCMP_HI)),
    .data(wr_data), .value(hcmp_enc)
  );
  vt_cmp_reg #(.VAL_W(CMP_W), .SCALED(1'b0)) u_vcmp (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (sel_e == SEL_VCMP_LO)),
    .wr_hi(wr_en && (sel_e == SEL_VCMP_HI)),
    .data(wr_data), .value(vcmp)
  );

  always_comb begin
    unique case (sel_e)
      SEL_HVSTAT:  rd_mux = hv_byte;
      SEL_NMISTAT: rd_mux = {nmi_flag, bus_in[6:4], VERSION};
      SEL_TMSTAT:  rd_mux = {timer_flag, bus_in[6:0]};
      default:     rd_mux = bus_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
  AST_HV_OPEN_BUS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == 3'd0) |=> (rd_data[5:1] == $past(bus_in[5:1]) && rd_data[0] == $past(poll_busy))); // R1
  AST_NMI_VERSION: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == 3'd1) |=> (rd_data[3:0] == VERSION && rd_data[7] == $past(nmi_flag))); // R4
  AST_TM_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == 3'd2) |=> (rd_data == {$past(timer_flag), $past(bus_in[6:0])})); // R5
  AST_VBL_DECODE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == 3'd0) |=> (rd_data[7] == ($past(vpos) >= $past(disp_height)))); // R3
  AST_HCMP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 3'd4) |=> (hcmp_enc[1:0] == 2'b00)); // R7
endmodule

// File: tb/vt_status_regs_tb.sv
module vt_status_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [7:0]  wr_data = 8'h00, bus_in = 8'h00;
  logic [10:0] hpos = 11'd100;
  logic [8:0]  vpos = 9'd10, disp_height = 9'd224;
  logic        poll_busy = 1'b0, nmi_set = 1'b0, timer_set = 1'b0;
  logic [7:0]  rd_data;
  logic        nmi_flag, timer_flag;
  logic [11:0] hcmp_enc;
  logic [8:0]  vcmp;

  int checks = 0, errors = 0;
  logic [8:0] hpos_model = 9'h1FF;

  always #2.5 clk = ~clk;

  vt_status_regs dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .bus_in(bus_in), .hpos(hpos), .vpos(vpos),
    .disp_height(disp_height), .poll_busy(poll_busy), .nmi_set(nmi_set),
    .timer_set(timer_set), .rd_data(rd_data), .nmi_flag(nmi_flag),
    .timer_flag(timer_flag), .hcmp_enc(hcmp_enc), .vcmp(vcmp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; sel = s;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic do_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [11:0] henc(input logic [8:0] n);
    return {({1'b0, n} + 10'd1), 2'b00};
  endfunction

  task automatic t_reset;
    check("R9 rd_data", rd_data, 8'h00);
    check("R9 nmi_flag", nmi_flag, 1'b0);
    check("R9 timer_flag", timer_flag, 1'b0);
    check("R9 vcmp", vcmp, 9'h1FF);
    check("R9 hcmp_enc", hcmp_enc, 12'h800);
  endtask

  task automatic t_hvstat;
    logic [7:0] v;
    bus_in = 8'b1010_1010; poll_busy = 1'b1; hpos = 11'd500; vpos = 9'd10;
    do_read(3'd0, v);
    check("R1 status poll+openbus", v, 8'b0010_1011);
    poll_busy = 1'b0; bus_in = 8'b0101_0101;
    do_read(3'd0, v);
    check("R1 status openbus", v, 8'b0001_0100);
    bus_in = 8'h00;
    hpos = 11'd2;    do_read(3'd0, v); check("R2 hpos=2", v[6], 1'b1);
    hpos = 11'd3;    do_read(3'd0, v); check("R2 hpos=3", v[6], 1'b0);
    hpos = 11'd1095; do_read(3'd0, v); check("R2 hpos=1095", v[6], 1'b0);
    hpos = 11'd1096; do_read(3'd0, v); check("R2 hpos=1096", v[6], 1'b1);
    hpos = 11'd0;    do_read(3'd0, v); check("R2 hpos=0", v[6], 1'b1);
    hpos = 11'd500;
    vpos = 9'd223; do_read(3'd0, v); check("R3 vpos=h-1", v[7], 1'b0);
    vpos = 9'd224; do_read(3'd0, v); check("R3 vpos=h", v[7], 1'b1);
    disp_height = 9'd239; vpos = 9'd238; do_read(3'd0, v); check("R3 vpos<h239", v[7], 1'b0);
    vpos = 9'd300; do_read(3'd0, v); check("R3 vpos>h", v[7], 1'b1);
  endtask

  task automatic t_flags;
    logic [7:0] v;
    bus_in = 8'hFF;
    do_read(3'd1, v); check("R4 nmi idle", v, 8'h72);
    @(negedge clk); nmi_set = 1'b1; @(negedge clk); nmi_set = 1'b0;
    check("R6 nmi set", nmi_flag, 1'b1);
    bus_in = 8'h00;
    do_read(3'd1, v); check("R4 nmi read", v, 8'h82);
    check("R6 nmi cleared", nmi_flag, 1'b0);
    @(negedge clk); timer_set = 1'b1; @(negedge clk); timer_set = 1'b0;
    bus_in = 8'h35;
    @(negedge clk); rd_en = 1'b1; sel = 3'd2; timer_set = 1'b1;
    @(negedge clk); rd_en = 1'b0; timer_set = 1'b0; v = rd_data;
    check("R5 timer read", v, 8'hB5);
    check("R6 timer kept on overlap", timer_flag, 1'b1);
    do_read(3'd2, v); check("R5 timer read2", v, 8'hB5);
    check("R6 timer cleared", timer_flag, 1'b0);
    @(negedge clk); rd_en = 1'b1; sel = 3'd1; nmi_set = 1'b1;
    @(negedge clk); rd_en = 1'b0; nmi_set = 1'b0; v = rd_data;
    check("R6 overlap returns old", v[7], 1'b0);
    check("R6 overlap sets", nmi_flag, 1'b1);
  endtask

  task automatic t_compare;
    do_write(3'd3, 8'h10); hpos_model[7:0] = 8'h10;
    check("R7 hcmp lo", hcmp_enc, henc(hpos_model));
    do_write(3'd4, 8'hFE); hpos_model[8] = 1'b0;
    check("R7 hcmp hi bit0=0", hcmp_enc, henc(hpos_model));
    do_write(3'd4, 8'h01); hpos_model[8] = 1'b1;
    check("R7 hcmp hi bit0=1", hcmp_enc, henc(hpos_model));
    do_write(3'd4, 8'h00); do_write(3'd3, 8'h00); hpos_model = 9'h000;
    check("R7 hcmp zero", hcmp_enc, 12'h004);
    check("R8 vcmp untouched", vcmp, 9'h1FF);
    do_write(3'd5, 8'h3C); check("R8 vcmp lo", vcmp, 9'h13C);
    do_write(3'd6, 8'hFE); check("R8 vcmp hi", vcmp, 9'h03C);
    check("R7 hcmp untouched", hcmp_enc, 12'h004);
  endtask

  task automatic t_other;
    logic [7:0] v;
    bus_in = 8'hC3; do_read(3'd7, v); check("R10 unmapped", v, 8'hC3);
    bus_in = 8'h5A; do_read(3'd3, v); check("R10 write-only sel", v, 8'h5A);
    bus_in = 8'h11; repeat (3) @(negedge clk);
    check("R10 hold", rd_data, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hvstat();
    t_flags();
    t_compare();
    t_other();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule